// File: doc/BRIEF.md
# Camera frame capture packer

This block takes a monochrome frame from an 8-bit parallel camera stream and hands it to a processor in bursts of eight 32-bit words. Software raises a start input. The block then waits for the next start of a frame, seen as a rising edge of the filtered frame-sync level. While the frame window is open, it takes every byte that is marked valid and packs each four bytes into one word.

Words collect in a first buffer level. When eight have arrived, the whole group is copied into a holding level and a request is raised. The processor reads the held words through an indexed read port and then acknowledges. If a second group completes while the held one is still waiting, the new group is discarded and a sticky overflow flag is set. Once every group of the frame has been acknowledged or discarded, a frame-done flag rises and the block goes idle until the next start. The default frame is 384 by 288 one-byte pixels, which is 3456 groups.

Top module: `frame_grab_packer`

## Requirements
- R1: After a synchronous active-high reset, grp_req_o, overflow_o and frame_done_o are all 0.
- R2: Before start_i is raised, no pixel is stored. If start_i arrives while the frame window is already open, storage waits for the next opening of the window.
- R3: A change on cam_fsync_i is accepted only after DEB_CYCLES consecutive clock samples at the new level. A shorter pulse has no effect. When the sync has been high from edge 1, the first byte stored is the one sampled at edge DEB_CYCLES+1.
- R4: Packing is little-endian. Byte 4j of a group goes to bits 7:0 of word j, and byte 4j+3 goes to bits 31:24.
- R5: After 32 stored bytes, grp_req_o rises. rd_data_o then shows held word rd_idx_i, where index 0 is the first word of the group.
- R6: grp_req_o stays high, and the held words stay unchanged, until grp_ack_i is sampled high. If no further group is complete, grp_req_o is low one cycle after the acknowledge.
- R7: If a group completes while the previous one is still unacknowledged, the new group is dropped, overflow_o is set and stays set, and the held words keep their values.
- R8: When all groups of a frame have been acknowledged or dropped, frame_done_o rises and stays high. After that, further pixels raise no request. A new start_i clears frame_done_o and overflow_o.
- R9: A byte with cam_pix_vld_i low, or one that arrives while the filtered frame window is closed, is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Software start request, accepted when idle |
| cam_fsync_i | input | 1 | Raw camera frame-window signal, high during a frame |
| cam_pix_vld_i | input | 1 | Pixel byte valid |
| cam_pix_i | input | PIX_W (8) | Pixel byte |
| rd_idx_i | input | log2(GROUP_WORDS) (3) | Index of the held word to read |
| rd_data_o | output | PIX_W*PACK (32) | Held word selected by rd_idx_i |
| grp_req_o | output | 1 | A group is held and ready for reading |
| grp_ack_i | input | 1 | Processor has finished reading the held group |
| overflow_o | output | 1 | Sticky flag: at least one group was dropped |
| frame_done_o | output | 1 | Sticky flag: all groups of the frame are retired |

## Verification
A packing-index or byte-lane fault shows up as wrong words at rd_data_o as soon as the first request rises, 32 stored bytes after the window opens. A filter count that is off by one shifts the first stored byte, and that is visible in word 0 of the first group. A coordinator that overwrites the holding stage, or that loses a group, shows up as changed held words while the request is still pending, as a missing overflow flag, or as a frame-done flag that is late or never comes after the last acknowledge.

// File: rtl/fgp_pkg.sv
package fgp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/fgp_sync_filter.sv
// Accepts a new sync level only after DEB_CYCLES consecutive samples differ
// from the accepted one; emits a one-cycle rise indication.
module fgp_sync_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic          level;
        logic          prev;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.prev = q.level;
        if (raw_i == q.level) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(DEB_CYCLES - 1)) begin
            d.level = raw_i;
            d.cnt   = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign level_o = q.level;
    assign rise_o  = q.level & ~q.prev;
endmodule

// File: rtl/fgp_byte_packer.sv
// Packs PACK consecutive bytes little-endian into one word; word_vld_o pulses
// for one cycle after the last byte of a word is taken.
module fgp_byte_packer #(
    parameter int PIX_W = 8,
    parameter int PACK  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  pix_en_i,
    input  logic [PIX_W-1:0]      pix_i,
    output logic [PIX_W*PACK-1:0] word_o,
    output logic                  word_vld_o
);
    localparam int WORD_W = PIX_W * PACK;
    localparam int IW     = $clog2(PACK);

    typedef struct packed {
        logic [IW-1:0]     idx;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] word;
        logic              vld;
    } pack_t;

    pack_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (clear_i) begin
            d.idx = '0;
        end else if (pix_en_i) begin
            d.acc[q.idx*PIX_W +: PIX_W] = pix_i;
            if (q.idx == IW'(PACK - 1)) begin
                d.word = d.acc;
                d.vld  = 1'b1;
                d.idx  = '0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign word_o     = q.word;
    assign word_vld_o = q.vld;
endmodule

// File: rtl/fgp_group_buffer.sv
// Two-level group store: a fill level and a holding level with the
// processor handshake. A group finding the holding level busy is dropped.
module fgp_group_buffer #(
    parameter int WORD_W      = 32,
    parameter int GROUP_WORDS = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clear_i,
    input  logic                           word_vld_i,
    input  logic [WORD_W-1:0]              word_i,
    input  logic                           ack_i,
    input  logic [$clog2(GROUP_WORDS)-1:0] rd_idx_i,
    output logic [WORD_W-1:0]              rd_data_o,
    output logic                           req_o,
    output logic                           drop_o,
    output logic                           retire_o
);
    localparam int IDXW = $clog2(GROUP_WORDS);

    typedef struct packed {
        logic [GROUP_WORDS-1:0][WORD_W-1:0] fill;
        logic [GROUP_WORDS-1:0][WORD_W-1:0] held;
        logic [IDXW-1:0]                    wr_idx;
        logic                               fill_full;
        logic                               hold;
        logic                               drop;
        logic                               retire;
    } gbuf_t;

    gbuf_t q, d;

    always_comb begin
        d        = q;
        d.drop   = 1'b0;
        d.retire = 1'b0;
        if (clear_i) begin
            d.wr_idx    = '0;
            d.fill_full = 1'b0;
            d.hold      = 1'b0;
        end else begin
            // processor releases the held group
            if (q.hold && ack_i) begin
                d.hold   = 1'b0;
                d.retire = 1'b1;
            end
            // coordinator: move a full fill level into the holding level
            if (q.fill_full) begin
                d.fill_full = 1'b0;
                if (!q.hold || ack_i) begin
                    d.held = q.fill;
                    d.hold = 1'b1;
                end else begin
                    d.drop = 1'b1;
                end
            end
            // producer: store a completed word
            if (word_vld_i) begin
                d.fill[q.wr_idx] = word_i;
                if (q.wr_idx == IDXW'(GROUP_WORDS - 1)) begin
                    d.wr_idx    = '0;
                    d.fill_full = 1'b1;
                end else begin
                    d.wr_idx = q.wr_idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_data_o = q.held[rd_idx_i];
    assign req_o     = q.hold;
    assign drop_o    = q.drop;
    assign retire_o  = q.retire;
endmodule

// File: rtl/frame_grab_packer.sv
module frame_grab_packer
    import fgp_pkg::*;
#(
    parameter int PIX_W       = 8,
    parameter int PACK        = 4,
    parameter int GROUP_WORDS = 8,
    parameter int LINE_PIX    = 384,
    parameter int FRAME_LINES = 288,
    parameter int DEB_CYCLES  = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic                           cam_fsync_i,
    input  logic                           cam_pix_vld_i,
    input  logic [PIX_W-1:0]               cam_pix_i,
    input  logic [$clog2(GROUP_WORDS)-1:0] rd_idx_i,
    output logic [PIX_W*PACK-1:0]          rd_data_o,
    output logic                           grp_req_o,
    input  logic                           grp_ack_i,
    output logic                           overflow_o,
    output logic                           frame_done_o
);
    localparam int WORD_W       = PIX_W * PACK;
    localparam int IDXW         = $clog2(GROUP_WORDS);
    localparam int FRAME_PIX    = LINE_PIX * FRAME_LINES;
    localparam int GROUP_PIX    = PACK * GROUP_WORDS;
    localparam int TOTAL_GROUPS = FRAME_PIX / GROUP_PIX;
    localparam int PCW          = $clog2(FRAME_PIX + 1);
    localparam int GCW          = $clog2(TOTAL_GROUPS + 1);

    typedef struct packed {
        cap_state_e     state;
        logic [PCW-1:0] pix_cnt;
        logic [GCW-1:0] grp_cnt;
        logic           overflow;
        logic           done;
    } ctl_t;

    ctl_t q, d;

    logic              win_level, win_rise;
    logic              clear, pix_en;
    logic [WORD_W-1:0] word;
    logic              word_vld;
    logic              drop, retire;

    fgp_sync_filter #(.DEB_CYCLES(DEB_CYCLES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (cam_fsync_i),
        .level_o (win_level),
        .rise_o  (win_rise)
    );

    fgp_byte_packer #(.PIX_W(PIX_W), .PACK(PACK)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear),
        .pix_en_i   (pix_en),
        .pix_i      (cam_pix_i),
        .word_o     (word),
        .word_vld_o (word_vld)
    );

    fgp_group_buffer #(.WORD_W(WORD_W), .GROUP_WORDS(GROUP_WORDS)) u_gbuf (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear),
        .word_vld_i (word_vld),
        .word_i     (word),
        .ack_i      (grp_ack_i),
        .rd_idx_i   (rd_idx_i),
        .rd_data_o  (rd_data_o),
        .req_o      (grp_req_o),
        .drop_o     (drop),
        .retire_o   (retire)
    );

    always_comb begin
        logic room;
        d      = q;
        clear  = 1'b0;
        pix_en = 1'b0;
        room   = (q.pix_cnt < PCW'(FRAME_PIX));
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state    = ST_ARMED;
                    d.pix_cnt  = '0;
                    d.grp_cnt  = '0;
                    d.overflow = 1'b0;
                    d.done     = 1'b0;
                    clear      = 1'b1;
                end
            end
            ST_ARMED: begin
                if (win_rise) begin
                    d.state = ST_CAPTURE;
                    pix_en  = cam_pix_vld_i && room;
                end
            end
            ST_CAPTURE: begin
                pix_en = win_level && cam_pix_vld_i && room;
            end
            default: d.state = ST_IDLE;
        endcase

        if (pix_en) d.pix_cnt = q.pix_cnt + 1'b1;
        if (drop)   d.overflow = 1'b1;
        if (q.state == ST_CAPTURE && (drop || retire)) begin
            d.grp_cnt = q.grp_cnt + 1'b1;
            if (q.grp_cnt == GCW'(TOTAL_GROUPS - 1)) begin
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state    <= ST_IDLE;
            q.pix_cnt  <= '0;
            q.grp_cnt  <= '0;
            q.overflow <= 1'b0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign overflow_o   = q.overflow;
    assign frame_done_o = q.done;
endmodule

// File: rtl/fgp_checker.sv
module fgp_checker #(
    parameter int WORD_W = 32,
    parameter int IDXW   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [IDXW-1:0]   rd_idx_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic              grp_req_o,
    input logic              grp_ack_i,
    input logic              overflow_o,
    input logic              frame_done_o
);
    // R6: an unacknowledged request stays up
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        grp_req_o && !grp_ack_i |=> grp_req_o);

    // R6 and R7: held words do not move while waiting, even if a group is dropped
    assert_held_stable_R6: assert property (@(posedge clk) disable iff (rst)
        grp_req_o && !grp_ack_i |=> ($stable(rd_idx_i) -> $stable(rd_data_o)));

    // R7: overflow is sticky until a new start
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        overflow_o && !start_i |=> overflow_o);

    // R8: frame-done is sticky until a new start
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done_o && !start_i |=> frame_done_o);

    // R8: a finished frame has no pending group
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> !grp_req_o);
endmodule

bind frame_grab_packer fgp_checker #(.WORD_W(WORD_W), .IDXW(IDXW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .rd_idx_i     (rd_idx_i),
    .rd_data_o    (rd_data_o),
    .grp_req_o    (grp_req_o),
    .grp_ack_i    (grp_ack_i),
    .overflow_o   (overflow_o),
    .frame_done_o (frame_done_o)
);

// File: tb/frame_grab_packer_tb.sv
module frame_grab_packer_tb;
    localparam int DEB    = 4;
    localparam int LP     = 16;
    localparam int FL     = 8;
    localparam int GPIX   = 32;
    localparam int GROUPS = LP * FL / GPIX;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        fsync = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  pix = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        req;
    logic        ack = 1'b0;
    logic        ovf;
    logic        done;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    frame_grab_packer #(
        .PIX_W(8), .PACK(4), .GROUP_WORDS(8),
        .LINE_PIX(LP), .FRAME_LINES(FL), .DEB_CYCLES(DEB)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cam_fsync_i(fsync),
        .cam_pix_vld_i(vld), .cam_pix_i(pix), .rd_idx_i(rd_idx),
        .rd_data_o(rd_data), .grp_req_o(req), .grp_ack_i(ack),
        .overflow_o(ovf), .frame_done_o(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int g, input int i);
        return 8'(g * 37 + i * 5 + 1);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0; fsync = 1'b0; vld = 1'b0; ack = 1'b0; pix = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic open_frame();
        @(negedge clk) fsync = 1'b1;
        repeat (DEB + 3) @(negedge clk);
    endtask

    // 32 valid bytes of group g, with invalid junk bytes between them (R9)
    task automatic feed_group(input int g);
        for (int i = 0; i < GPIX; i++) begin
            if (i % 5 == 4) begin
                @(negedge clk); vld = 1'b0; pix = 8'hAA;
            end
            @(negedge clk); vld = 1'b1; pix = pat(g, i);
        end
        @(negedge clk); vld = 1'b0; pix = '0;
    endtask

    task automatic wait_req(input string tag);
        int n = 0;
        while (!req && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {31'd0, req}, 32'd1);
    endtask

    task automatic check_group(input string tag, input int g);
        for (int k = 0; k < 8; k++) begin
            rd_idx = 3'(k);
            #1;
            chk(tag, rd_data, {pat(g, 4*k+3), pat(g, 4*k+2), pat(g, 4*k+1), pat(g, 4*k)});
        end
    endtask

    task automatic ack_group();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        chk("R6 request drops after ack", {31'd0, req}, 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req after reset", {31'd0, req}, 32'd0);
        chk("R1 overflow after reset", {31'd0, ovf}, 32'd0);
        chk("R1 done after reset", {31'd0, done}, 32'd0);
    endtask

    task automatic t_no_start();
        do_reset();
        open_frame();
        feed_group(0);
        feed_group(1);
        repeat (10) @(negedge clk);
        chk("R2 no storage without start", {31'd0, req}, 32'd0);
        fsync = 1'b0;
    endtask

    // sync high from edge 1, byte k presented at edge k
    task automatic t_latency();
        do_reset();
        pulse_start();
        for (int k = 1; k <= 40; k++) begin
            fsync = 1'b1; vld = 1'b1; pix = 8'(k);
            @(negedge clk);
        end
        vld = 1'b0;
        wait_req("R5 request after 32 bytes");
        rd_idx = 3'd0; #1;
        chk("R3 first stored byte at edge DEB+1", rd_data,
            {8'(DEB+4), 8'(DEB+3), 8'(DEB+2), 8'(DEB+1)});
        rd_idx = 3'd7; #1;
        chk("R4 last word lanes", rd_data,
            {8'(DEB+32), 8'(DEB+31), 8'(DEB+30), 8'(DEB+29)});
    endtask

    task automatic t_midframe_full();
        do_reset();
        fsync = 1'b1;
        repeat (10) @(negedge clk);
        pulse_start();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); vld = 1'b1; pix = 8'hEE;
        end
        @(negedge clk); vld = 1'b0; fsync = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < DEB - 1; i++) begin
            fsync = 1'b1; vld = 1'b1; pix = 8'hDD;
            @(negedge clk);
        end
        fsync = 1'b0; vld = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 R3 nothing stored before a real frame", {31'd0, req}, 32'd0);
        open_frame();
        for (int g = 0; g < GROUPS; g++) begin
            feed_group(g);
            wait_req("R5 request per group");
            check_group("R4 R5 R9 group contents", g);
            if (g == 0) begin
                repeat (6) @(negedge clk);
                chk("R6 request held without ack", {31'd0, req}, 32'd1);
                check_group("R6 held words stable", 0);
            end
            ack_group();
        end
        repeat (5) @(negedge clk);
        chk("R8 frame done", {31'd0, done}, 32'd1);
        chk("R7 no overflow on clean frame", {31'd0, ovf}, 32'd0);
        feed_group(9);
        repeat (10) @(negedge clk);
        chk("R8 idle after done", {31'd0, req}, 32'd0);
        fsync = 1'b0;
    endtask

    task automatic t_overflow();
        do_reset();
        pulse_start();
        open_frame();
        feed_group(0);
        wait_req("R5 first group");
        feed_group(1);
        repeat (5) @(negedge clk);
        chk("R7 overflow set", {31'd0, ovf}, 32'd1);
        chk("R7 request still pending", {31'd0, req}, 32'd1);
        check_group("R7 held group kept", 0);
        ack_group();
        for (int g = 2; g < GROUPS; g++) begin
            feed_group(g);
            wait_req("R5 later group");
            check_group("R7 later group intact", g);
            ack_group();
        end
        repeat (5) @(negedge clk);
        chk("R8 done counts dropped group", {31'd0, done}, 32'd1);
        chk("R7 overflow sticky", {31'd0, ovf}, 32'd1);
        fsync = 1'b0;
        pulse_start();
        @(negedge clk);
        chk("R8 start clears done", {31'd0, done}, 32'd0);
        chk("R8 start clears overflow", {31'd0, ovf}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_no_start();
        t_latency();
        t_midframe_full();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule